// File: doc/BRIEF.md
# Cartridge ROM Bank Window Mapper

This block sits between a 24-bit byte-addressed CPU bus and a cartridge ROM that is larger than the CPU can see at once. The lowest 4 MB of the CPU address space is the cartridge region. It is cut into eight windows of 512 KB each. A CPU address in window w is turned into a physical ROM address by putting the bank number assigned to that window above the low 19 address bits. Window 0 is fixed to bank 0, so reset vectors and boot code are always reachable. Windows 1 to 7 each have a bank register that software can rewrite at run time.

The bank registers and one SRAM control register sit in a 16-byte register page at 0xA130F0. Only the odd bytes of the page hold registers, and they are reached with byte accesses only. The control register can move the top window from ROM to a battery-backed SRAM, and it can write-protect that SRAM. The translation, the register page decode, the reset mapping and the ROM/SRAM selects are all combinational from the current request. Register writes are captured on the clock edge that ends the bus cycle.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, window n maps to bank n for n = 0..7 (identity mapping), and the SRAM control register reads 0.
- R2: An aligned read with cpu_valid high to an address below 0x400000 asserts rom_sel, and rom_addr equals bank(w) * 0x80000 + (cpu_addr mod 0x80000), where w = cpu_addr[21:19]. Window 0 always uses bank 0.
- R3: A byte write (cpu_size = 0) to odd address 0xA130F0 + 2k + 1, for k = 1..7, loads cpu_wdata[5:0] into the bank register of window k. The new mapping is in effect from the next clock cycle.
- R4: A byte read of the page returns, in cpu_rdata, the following values. Offset 0x1 gives the SRAM control register in bits [1:0] with zeros above. Offset 2k+1 (k = 1..7) gives the window k bank number zero-extended. Even offsets return 0. cpu_rdata is 0 whenever no byte read of the page is in progress.
- R5: Writes have no effect on any register if they are word or long writes, writes to even page offsets, or writes with cpu_valid low.
- R6: A word (cpu_size = 1) or long (cpu_size = 2 or 3) access to an odd address asserts align_err. It selects neither ROM nor SRAM, and it changes no register.
- R7: A byte write to offset 0x1 loads cpu_wdata[1:0] into the SRAM control register. While bit 0 (enable) is set, accesses to window 7 assert sram_sel instead of rom_sel. Other windows are unaffected.
- R8: sram_wr_en is high only for a write while sram_sel is high and bit 1 (write protect) is clear. sram_addr carries cpu_addr[15:0].
- R9: Writes into the cartridge region that do not reach SRAM assert neither rom_sel nor sram_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Bus cycle in progress |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 word, 2/3 long |
| cpu_addr | input | 24 | CPU byte address |
| cpu_wdata | input | 8 | Write data for register page |
| cpu_rdata | output | 8 | Register page read data |
| rom_sel | output | 1 | ROM read select |
| rom_addr | output | 25 | Translated physical ROM byte address |
| sram_sel | output | 1 | SRAM select for the top window |
| sram_wr_en | output | 1 | SRAM write enable after write protect |
| sram_addr | output | 16 | SRAM byte address |
| align_err | output | 1 | Word/long access at an odd address |

## Verification
A wrong bank register can only show up on rom_addr during a read of its own window. It can also be read back through the register page. The bench therefore follows every write pass with a sweep of all eight windows at several offsets and a sweep of all sixteen page bytes, one cycle after the write. A corrupted SRAM control bit changes which of rom_sel and sram_sel rises in window 7 on the very access that follows, so every enable/protect combination is checked with reads and writes in windows 6 and 7. Ignored writes are caught by repeating the full readback and translation sweep directly after them.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int CTL_EN_BIT = 0;
  localparam int CTL_WP_BIT = 1;
  localparam int CTL_W      = 2;

endpackage

// File: rtl/cbm_bus_decode.sv
module cbm_bus_decode
  import cbm_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                WIN_BITS  = 19,
  parameter int                NUM_WIN   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE  = 24'hA130F0,
  localparam int               WIN_IDX_W = $clog2(NUM_WIN),
  localparam int               CART_TOP  = WIN_BITS + WIN_IDX_W,
  localparam int               REG_OFF_W = WIN_IDX_W + 1
) (
  input  logic                 valid,
  input  logic                 we,
  input  acc_size_e            size,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cart_hit,
  output logic [WIN_IDX_W-1:0] win_idx,
  output logic                 reg_wr,
  output logic                 reg_rd,
  output logic [WIN_IDX_W-1:0] reg_idx,
  output logic                 align_err
);

  logic misalign;
  logic in_cart;
  logic in_page;
  logic reg_acc;

  always_comb begin
    misalign  = (size != SZ_BYTE) && addr[0];
    in_cart   = (addr[ADDR_W-1:CART_TOP] == '0);
    in_page   = (addr[ADDR_W-1:REG_OFF_W] == REG_BASE[ADDR_W-1:REG_OFF_W]);
    reg_acc   = valid && in_page && addr[0] && (size == SZ_BYTE);

    align_err = valid && misalign;
    cart_hit  = valid && !misalign && in_cart;
    win_idx   = addr[CART_TOP-1:WIN_BITS];
    reg_wr    = reg_acc && we;
    reg_rd    = reg_acc && !we;
    reg_idx   = addr[REG_OFF_W-1:1];
  end

endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
  import cbm_pkg::*;
#(
  parameter int  NUM_WIN   = 8,
  parameter int  BANK_W    = 6,
  parameter int  DATA_W    = 8,
  localparam int WIN_IDX_W = $clog2(NUM_WIN)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_stb,
  input  logic                              rd_stb,
  input  logic [WIN_IDX_W-1:0]              reg_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_WIN-1:0][BANK_W-1:0]    bank_o,
  output logic                              sram_en,
  output logic                              sram_wp,
  output logic [DATA_W-1:0]                 rd_data
);

  // SRAM control register: next state and register process
  logic              ctl_en;
  logic [CTL_W-1:0]  ctl_d;
  logic [CTL_W-1:0]  ctl_q;

  always_comb begin
    ctl_en = wr_stb && (reg_idx == '0);
    ctl_d  = wr_data[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign sram_en = ctl_q[CTL_EN_BIT];
  assign sram_wp = ctl_q[CTL_WP_BIT];

  // Window 0 carries no register
  assign bank_o[0] = '0;

  for (genvar w = 1; w < NUM_WIN; w++) begin : g_win
    logic              q_en;
    logic [BANK_W-1:0] q_d;
    logic [BANK_W-1:0] q;

    always_comb begin
      q_en = wr_stb && (reg_idx == WIN_IDX_W'(w));
      q_d  = wr_data[BANK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= BANK_W'(w);
      else if (q_en) q <= q_d;
    end

    assign bank_o[w] = q;

    // R3
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && reg_idx == WIN_IDX_W'(w)) |=> (q == $past(wr_data[BANK_W-1:0])));
  end

  if (DATA_W > BANK_W) begin : g_unused
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wr_data[DATA_W-1:BANK_W];
  end

  always_comb begin
    rd_data = '0;
    if (rd_stb) begin
      if (reg_idx == '0) rd_data = DATA_W'(ctl_q);
      else               rd_data = DATA_W'(bank_o[reg_idx]);
    end
  end

  // R7
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_idx == '0) |=> (ctl_q == $past(wr_data[CTL_W-1:0])));

endmodule

// File: rtl/cbm_translate.sv
module cbm_translate #(
  parameter int  NUM_WIN   = 8,
  parameter int  BANK_W    = 6,
  parameter int  WIN_BITS  = 19,
  parameter int  SRAM_AW   = 16,
  localparam int WIN_IDX_W = $clog2(NUM_WIN),
  localparam int PHYS_W    = BANK_W + WIN_BITS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic                           cart_hit,
  input  logic [WIN_IDX_W-1:0]           win_idx,
  input  logic [WIN_BITS-1:0]            addr_lo,
  input  logic [NUM_WIN-1:0][BANK_W-1:0] bank_i,
  input  logic                           sram_en,
  input  logic                           sram_wp,
  output logic [PHYS_W-1:0]              rom_addr,
  output logic                           rom_sel,
  output logic                           sram_sel,
  output logic                           sram_wr_en,
  output logic [SRAM_AW-1:0]             sram_addr
);

  localparam logic [WIN_IDX_W-1:0] TOP_WIN = WIN_IDX_W'(NUM_WIN - 1);

  logic to_sram;

  always_comb begin
    to_sram    = cart_hit && sram_en && (win_idx == TOP_WIN);
    rom_addr   = {bank_i[win_idx], addr_lo};
    rom_sel    = cart_hit && !to_sram && !we;
    sram_sel   = to_sram;
    sram_wr_en = to_sram && we && !sram_wp;
    sram_addr  = addr_lo[SRAM_AW-1:0];
  end

  // R7
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, sram_sel}));

  // R8
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_en |-> (sram_en && !sram_wp && we));

  // R2
  win0_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && win_idx == '0) |-> (rom_addr[PHYS_W-1:WIN_BITS] == '0));

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                DATA_W   = 8,
  parameter int                NUM_WIN  = 8,
  parameter int                WIN_BITS = 19,
  parameter int                BANK_W   = 6,
  parameter int                SRAM_AW  = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hA130F0,
  localparam int               WIN_IDX_W = $clog2(NUM_WIN),
  localparam int               PHYS_W    = BANK_W + WIN_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  input  logic                 cpu_we,
  input  logic [1:0]           cpu_size,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 rom_sel,
  output logic [PHYS_W-1:0]    rom_addr,
  output logic                 sram_sel,
  output logic                 sram_wr_en,
  output logic [SRAM_AW-1:0]   sram_addr,
  output logic                 align_err
);

  acc_size_e                   size_e;
  logic                        cart_hit;
  logic [WIN_IDX_W-1:0]        win_idx;
  logic                        reg_wr;
  logic                        reg_rd;
  logic [WIN_IDX_W-1:0]        reg_idx;
  logic [NUM_WIN-1:0][BANK_W-1:0] bank_map;
  logic                        sram_en;
  logic                        sram_wp;

  assign size_e = acc_size_e'(cpu_size);

  cbm_bus_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .NUM_WIN  (NUM_WIN),
    .REG_BASE (REG_BASE)
  ) i_decode (
    .valid     (cpu_valid),
    .we        (cpu_we),
    .size      (size_e),
    .addr      (cpu_addr),
    .cart_hit  (cart_hit),
    .win_idx   (win_idx),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_idx   (reg_idx),
    .align_err (align_err)
  );

  cbm_bank_regs #(
    .NUM_WIN (NUM_WIN),
    .BANK_W  (BANK_W),
    .DATA_W  (DATA_W)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (reg_wr),
    .rd_stb  (reg_rd),
    .reg_idx (reg_idx),
    .wr_data (cpu_wdata),
    .bank_o  (bank_map),
    .sram_en (sram_en),
    .sram_wp (sram_wp),
    .rd_data (cpu_rdata)
  );

  cbm_translate #(
    .NUM_WIN  (NUM_WIN),
    .BANK_W   (BANK_W),
    .WIN_BITS (WIN_BITS),
    .SRAM_AW  (SRAM_AW)
  ) i_xlate (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cpu_we),
    .cart_hit   (cart_hit),
    .win_idx    (win_idx),
    .addr_lo    (cpu_addr[WIN_BITS-1:0]),
    .bank_i     (bank_map),
    .sram_en    (sram_en),
    .sram_wp    (sram_wp),
    .rom_addr   (rom_addr),
    .rom_sel    (rom_sel),
    .sram_sel   (sram_sel),
    .sram_wr_en (sram_wr_en),
    .sram_addr  (sram_addr)
  );

  // R6
  misalign_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!rom_sel && !sram_sel && cpu_rdata == '0));

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_we && cpu_size == 2'd0 && cpu_addr[0])
      |=> ($stable(bank_map) && $stable(sram_en) && $stable(sram_wp)));

  // R4
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && !cpu_we) |-> (cpu_rdata == '0));

  // R9
  rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we) |-> !rom_sel);

endmodule

// File: tb/test_cart_bank_mapper.sv
module test_cart_bank_mapper;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NW   = 8;
  localparam int  WB   = 19;
  localparam logic [23:0] PAGE = 24'hA130F0;

  logic        clk;
  logic        rst_n;
  logic        cpu_valid;
  logic        cpu_we;
  logic [1:0]  cpu_size;
  logic [23:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        rom_sel;
  logic [24:0] rom_addr;
  logic        sram_sel;
  logic        sram_wr_en;
  logic [15:0] sram_addr;
  logic        align_err;

  int checks;
  int errors;
  int exp_bank [NW];
  int exp_ctl;

  cart_bank_mapper i_cart_bank_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_we     (cpu_we),
    .cpu_size   (cpu_size),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .rom_sel    (rom_sel),
    .rom_addr   (rom_addr),
    .sram_sel   (sram_sel),
    .sram_wr_en (sram_wr_en),
    .sram_addr  (sram_addr),
    .align_err  (align_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [1:0] sz,
                       input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_valid = v; cpu_we = w; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 2'd0, 24'h0, 8'h0);
  endtask

  task automatic reg_write(input logic v, input logic [1:0] sz,
                           input logic [23:0] a, input logic [7:0] d);
    drive(v, 1'b1, sz, a, d);
    idle();
  endtask

  // R2: translation of every window at three offsets
  task automatic check_map(input string req);
    int offs [3] = '{0, 32'h7FFFF, 32'h2A5A5};
    for (int w = 0; w < NW; w++) begin
      for (int o = 0; o < 3; o++) begin
        logic [23:0] a;
        a = 24'((w << WB) | offs[o]);
        drive(1'b1, 1'b0, 2'd0, a, 8'h0);
        chk(req, $sformatf("rom_sel w%0d", w), 32'(rom_sel), 1);
        chk(req, $sformatf("rom_addr w%0d off %h", w, offs[o]), 32'(rom_addr),
            32'((exp_bank[w] << WB) | offs[o]));
      end
    end
    idle();
  endtask

  // R4: all 16 page bytes read back
  task automatic check_regs(input string req);
    for (int k = 0; k < 16; k++) begin
      int exp;
      drive(1'b1, 1'b0, 2'd0, PAGE + 24'(k), 8'h0);
      if (k % 2 == 0)   exp = 0;
      else if (k == 1)  exp = exp_ctl;
      else              exp = exp_bank[k/2];
      chk(req, $sformatf("rdata off %0d", k), 32'(cpu_rdata), 32'(exp));
    end
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    cpu_valid = 0; cpu_we = 0; cpu_size = 0; cpu_addr = 0; cpu_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: identity mapping and cleared control after reset
    for (int w = 0; w < NW; w++) exp_bank[w] = w;
    exp_ctl = 0;
    check_map("R1");
    check_regs("R1");
    idle();
    chk("R4", "rdata idle", 32'(cpu_rdata), 0);

    // R3: load a pattern, upper data bits dropped
    for (int k = 1; k < NW; k++) begin
      exp_bank[k] = (k * 13 + 5) % 64;
      reg_write(1'b1, 2'd0, PAGE + 24'(2*k + 1), 8'(exp_bank[k]) | 8'hC0);
    end
    check_map("R3");
    check_regs("R3");

    // R3: second pattern, next-cycle visibility
    for (int k = 1; k < NW; k++) begin
      exp_bank[k] = 63 - k;
      reg_write(1'b1, 2'd0, PAGE + 24'(2*k + 1), 8'(exp_bank[k]));
      drive(1'b1, 1'b0, 2'd0, 24'((k << WB) | 5), 8'h0);
      chk("R3", $sformatf("next cycle w%0d", k), 32'(rom_addr),
          32'((exp_bank[k] << WB) | 5));
    end
    idle();

    // R5: ignored writes
    reg_write(1'b1, 2'd1, PAGE + 24'h2, 8'h00);
    reg_write(1'b1, 2'd2, PAGE + 24'h4, 8'h00);
    reg_write(1'b1, 2'd0, PAGE + 24'h6, 8'h00);
    reg_write(1'b0, 2'd0, PAGE + 24'h3, 8'h00);
    reg_write(1'b0, 2'd0, PAGE + 24'h1, 8'h03);
    reg_write(1'b1, 2'd3, PAGE + 24'h8, 8'h00);
    check_regs("R5");
    check_map("R5");

    // R6: alignment
    drive(1'b1, 1'b0, 2'd1, 24'h000001, 8'h0);
    chk("R6", "align_err word odd", 32'(align_err), 1);
    chk("R6", "rom_sel word odd", 32'(rom_sel), 0);
    drive(1'b1, 1'b0, 2'd2, 24'h080003, 8'h0);
    chk("R6", "align_err long odd", 32'(align_err), 1);
    chk("R6", "rom_sel long odd", 32'(rom_sel), 0);
    drive(1'b1, 1'b0, 2'd1, 24'h000002, 8'h0);
    chk("R6", "align_err word even", 32'(align_err), 0);
    chk("R6", "rom_sel word even", 32'(rom_sel), 1);
    drive(1'b1, 1'b0, 2'd0, 24'h000001, 8'h0);
    chk("R6", "align_err byte odd", 32'(align_err), 0);
    reg_write(1'b1, 2'd1, PAGE + 24'h3, 8'h00);
    check_regs("R6");

    // R7 R8 R9: every control value, windows 6 and 7, read and write
    for (int c = 0; c < 4; c++) begin
      exp_ctl = c;
      reg_write(1'b1, 2'd0, PAGE + 24'h1, 8'(c) | 8'hFC);
      drive(1'b1, 1'b0, 2'd0, PAGE + 24'h1, 8'h0);
      chk("R7", "ctl readback", 32'(cpu_rdata), 32'(c));
      for (int w = 6; w < 8; w++) begin
        for (int we = 0; we < 2; we++) begin
          logic es;
          es = (c & 1) && (w == 7);
          drive(1'b1, 1'(we), 2'd0, 24'((w << WB) | 16'hBEEF), 8'h0);
          chk("R7", $sformatf("sram_sel c%0d w%0d we%0d", c, w, we),
              32'(sram_sel), 32'(es));
          chk("R9", $sformatf("rom_sel c%0d w%0d we%0d", c, w, we),
              32'(rom_sel), 32'(!es && we == 0));
          chk("R8", $sformatf("sram_wr_en c%0d w%0d we%0d", c, w, we),
              32'(sram_wr_en), 32'(es && we == 1 && !(c & 2)));
          if (es) chk("R8", "sram_addr", 32'(sram_addr), 32'h0000BEEF);
        end
      end
    end
    idle();
    exp_ctl = 0;
    reg_write(1'b1, 2'd0, PAGE + 24'h1, 8'h00);
    check_map("R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule